// File: doc/BRIEF.md
# Jittered Periodic Trigger Generator

This block makes internal trigger strobes for a measurement front end. Each strobe is a single clock cycle wide. The time from one strobe to the next is a programmable base period `M`. A pseudo-random extension can be added to it, and its span is chosen by an exponent `N`. With `N = 0` the strobes repeat every `M` cycles exactly. With `N > 0` each interval is stretched by a fresh value between 0 and 2^N − 1, so the triggers arrive at irregular times.

The block also keeps a free-running 32-bit count of issued strobes. An enable input starts and stops the generator. Dropping enable throws away the interval in progress, and raising it again starts a fresh full interval. The period and exponent inputs are sampled only when a new interval is drawn. A change made mid-interval therefore applies from the next strobe onward.

At a 4 ns clock, the base settings `M = 62500`, `N = 0` produce one trigger every 250 µs, which is 4 kHz.

Top module: `jitter_trig_gen`

## Requirements
- R1: While reset is held, and on the first cycle after a reset edge, `trig_pulse` is 0 and `trig_count` is 0.
- R2: With `rand_exp = 0`, strobes are exactly `base_period` cycles apart; `base_period = 62500` gives a 62500-cycle spacing.
- R3: Each interval length is `base_period + (L & (2^rand_exp − 1))`. `L` is a 32-bit LFSR, seeded with 1, that shifts left and takes as its new bit 0 the XOR of bits 31, 21, 1 and 0. `L` is read and then stepped once per draw. A draw happens on the first enabled edge and on every strobe edge, and the LFSR keeps its state while disabled.
- R4: An interval that computes to zero (`base_period = 0` with a zero random term) is taken as 1 cycle, so strobes occur on consecutive cycles.
- R5: A change to `base_period` or `rand_exp` in the middle of an interval leaves that interval unchanged and applies to the interval drawn at the next strobe.
- R6: When `enable` is sampled low, no strobe follows and the interval in progress is dropped; `trig_count` holds. Take the first edge that samples `enable` high again. The first strobe is then visible in the cycle after the edge that comes one full interval later.
- R7: `trig_count` rises by exactly 1 at the same edge that raises `trig_pulse`, and is unchanged at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run control; low stops and rearms the generator |
| base_period | input | 32 | Base interval `M` in cycles |
| rand_exp | input | 5 | Random exponent `N` (0 to 31) |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| trig_count | output | 32 | Number of strobes since reset, wrapping |

## Verification
The checker watches every cycle. It keeps the gap between consecutive strobes inside the bounds set by the parameters latched at the draw, and requires that gap to be exact when the exponent is zero. It also confirms that the counter steps by one with each strobe and holds otherwise, and that nothing fires after enable is sampled low. Several behaviours can only be shown by the bench's scenarios. These are the exact random sequence drawn from the LFSR, the delay between a parameter change and the strobe where it takes effect, the zero-period clamp, and the restart timing after enable is dropped and raised again.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

   // Countdown timer phases
   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_e;

   // Feedback mask for the 32-bit shift-left LFSR (bits 31, 21, 1, 0)
   localparam logic [31:0] LFSR32_TAPS = 32'h8020_0003;
   localparam logic [31:0] LFSR32_SEED = 32'h0000_0001;

endpackage

// File: rtl/trig_lfsr.sv
`timescale 1ns/1ps
module trig_lfsr #(
   parameter int          WIDTH = 32,
   parameter logic [WIDTH-1:0] TAPS  = trig_pkg::LFSR32_TAPS,
   parameter logic [WIDTH-1:0] SEED  = trig_pkg::LFSR32_SEED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [WIDTH-1:0] word
);

   logic feedback;

   initial begin
      assert (WIDTH >= 2) else $error("trig_lfsr: WIDTH too small");
      assert (SEED != '0) else $error("trig_lfsr: all-zero seed locks up");
   end

   assign feedback = ^(word & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n)
         word <= SEED;
      else if (step)
         word <= {word[WIDTH-2:0], feedback};
   end

endmodule

// File: rtl/trig_interval.sv
`timescale 1ns/1ps
module trig_interval #(
   parameter int PERIOD_W  = 32,
   parameter int EXP_W     = 5,
   parameter int RAND_W    = 32,
   parameter int SUM_W     = 33,
   parameter bit JITTER_EN = 1'b1
) (
   input  logic [PERIOD_W-1:0] base_period,
   input  logic [EXP_W-1:0]    rand_exp,
   input  logic [RAND_W-1:0]   rand_word,
   output logic [SUM_W-1:0]    interval
);

   logic [SUM_W-1:0] offset;
   logic [SUM_W-1:0] raw_sum;

   generate
      if (JITTER_EN) begin : g_jitter
         logic [RAND_W-1:0] keep;
         for (genvar b = 0; b < RAND_W; b++) begin : g_mask
            assign keep[b] = (32'(rand_exp) > b);
         end
         assign offset = SUM_W'(rand_word & keep);
      end else begin : g_fixed
         assign offset = '0;
      end
   endgenerate

   assign raw_sum  = SUM_W'(base_period) + offset;
   // A zero interval cannot be counted down: clamp to one cycle
   assign interval = (raw_sum == '0) ? SUM_W'(1) : raw_sum;

endmodule

// File: rtl/trig_timer.sv
`timescale 1ns/1ps
module trig_timer
   import trig_pkg::*;
#(
   parameter int SUM_W   = 33,
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [SUM_W-1:0]   interval,
   output logic               draw,
   output logic               trig_pulse,
   output logic [COUNT_W-1:0] trig_count
);

   tmr_state_e       state;
   logic [SUM_W-1:0] remain;
   logic             expire;

   assign expire = (state == TMR_RUN) && (remain == SUM_W'(1));
   assign draw   = enable && ((state == TMR_IDLE) || expire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= TMR_IDLE;
         remain     <= '0;
         trig_pulse <= 1'b0;
         trig_count <= '0;
      end else begin
         trig_pulse <= 1'b0;
         if (!enable) begin
            state <= TMR_IDLE;
         end else if (state == TMR_IDLE) begin
            state  <= TMR_RUN;
            remain <= interval;
         end else if (expire) begin
            remain     <= interval;
            trig_pulse <= 1'b1;
            trig_count <= trig_count + COUNT_W'(1);
         end else begin
            remain <= remain - SUM_W'(1);
         end
      end
   end

endmodule

// File: rtl/jitter_trig_gen.sv
`timescale 1ns/1ps
module jitter_trig_gen #(
   parameter int PERIOD_W  = 32,
   parameter int EXP_W     = 5,
   parameter int RAND_W    = 32,
   parameter int COUNT_W   = 32,
   parameter bit JITTER_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [PERIOD_W-1:0] base_period,
   input  logic [EXP_W-1:0]    rand_exp,
   output logic                trig_pulse,
   output logic [COUNT_W-1:0]  trig_count
);

   localparam int WIDEST = (PERIOD_W > RAND_W) ? PERIOD_W : RAND_W;
   localparam int SUM_W  = WIDEST + 1;

   initial begin
      assert (PERIOD_W >= 2) else $error("jitter_trig_gen: PERIOD_W too small");
      assert (EXP_W >= 1 && EXP_W <= 6) else $error("jitter_trig_gen: EXP_W out of range");
      assert ((2 ** EXP_W) - 1 <= RAND_W) else $error("jitter_trig_gen: RAND_W cannot cover exponent");
      assert (COUNT_W >= 1) else $error("jitter_trig_gen: COUNT_W too small");
   end

   logic [RAND_W-1:0] rand_word;
   logic [SUM_W-1:0]  interval;
   logic              draw;

   generate
      if (JITTER_EN) begin : g_rng
         trig_lfsr #(
            .WIDTH (RAND_W),
            .TAPS  (RAND_W'(trig_pkg::LFSR32_TAPS)),
            .SEED  (RAND_W'(trig_pkg::LFSR32_SEED))
         ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (draw),
            .word  (rand_word)
         );
      end else begin : g_no_rng
         assign rand_word = '0;
      end
   endgenerate

   trig_interval #(
      .PERIOD_W  (PERIOD_W),
      .EXP_W     (EXP_W),
      .RAND_W    (RAND_W),
      .SUM_W     (SUM_W),
      .JITTER_EN (JITTER_EN)
   ) u_interval (
      .base_period (base_period),
      .rand_exp    (rand_exp),
      .rand_word   (rand_word),
      .interval    (interval)
   );

   trig_timer #(
      .SUM_W   (SUM_W),
      .COUNT_W (COUNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .interval   (interval),
      .draw       (draw),
      .trig_pulse (trig_pulse),
      .trig_count (trig_count)
   );

endmodule

// File: rtl/trig_gen_checker.sv
`timescale 1ns/1ps
module trig_gen_checker #(
   parameter int PERIOD_W = 32,
   parameter int EXP_W    = 5,
   parameter int COUNT_W  = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                enable,
   input logic [PERIOD_W-1:0] base_period,
   input logic [EXP_W-1:0]    rand_exp,
   input logic                trig_pulse,
   input logic [COUNT_W-1:0]  trig_count
);

   localparam int GAP_W = PERIOD_W + 2;

   logic [PERIOD_W-1:0] m_prev, m_lat;
   logic [EXP_W-1:0]    n_prev, n_lat;
   logic [GAP_W-1:0]    gap, span, lo, lo_eff, hi, hi_eff;
   logic                armed;

   // Parameters seen at the draw edge are the ones registered one edge earlier
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_prev <= '0;
         n_prev <= '0;
         m_lat  <= '0;
         n_lat  <= '0;
         gap    <= '0;
         armed  <= 1'b0;
      end else begin
         m_prev <= base_period;
         n_prev <= rand_exp;
         if (!enable) begin
            armed <= 1'b0;
            gap   <= '0;
         end else if (trig_pulse) begin
            armed <= 1'b1;
            gap   <= GAP_W'(1);
            m_lat <= m_prev;
            n_lat <= n_prev;
         end else begin
            gap <= gap + GAP_W'(1);
         end
      end
   end

   assign span   = (GAP_W'(1) << n_lat) - GAP_W'(1);
   assign lo     = GAP_W'(m_lat);
   assign lo_eff = (lo == '0) ? GAP_W'(1) : lo;
   assign hi     = lo + span;
   assign hi_eff = (hi == '0) ? GAP_W'(1) : hi;

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!trig_pulse && trig_count == '0));

   assert_exact_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && trig_pulse && n_lat == '0) |-> (gap == lo_eff));

   assert_gap_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && trig_pulse) |-> (gap >= lo_eff && gap <= hi_eff));

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !trig_pulse);

   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> (trig_count == COUNT_W'($past(trig_count) + 1'b1)));

   assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_pulse |-> $stable(trig_count));

endmodule

bind jitter_trig_gen trig_gen_checker #(
   .PERIOD_W (PERIOD_W),
   .EXP_W    (EXP_W),
   .COUNT_W  (COUNT_W)
) u_trig_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .base_period (base_period),
   .rand_exp    (rand_exp),
   .trig_pulse  (trig_pulse),
   .trig_count  (trig_count)
);

// File: tb/tb_jitter_trig_gen.sv
`timescale 1ns/1ps
module tb_jitter_trig_gen;

   localparam int PW = 32;
   localparam int EW = 5;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [PW-1:0] base_period = '0;
   logic [EW-1:0] rand_exp = '0;
   logic          trig_pulse;
   logic [CW-1:0] trig_count;

   always #2 clk = ~clk;   // 250 MHz

   jitter_trig_gen dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .base_period (base_period),
      .rand_exp    (rand_exp),
      .trig_pulse  (trig_pulse),
      .trig_count  (trig_count)
   );

   int          vec = 0;
   int          bad = 0;
   bit          done = 1'b0;
   longint      cyc = 0;
   longint      exp_q[$];
   string       req_q[$];
   logic [31:0] mdl_lfsr = 32'h1;
   longint      mdl_cnt = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic logic [31:0] lfsr_next(input logic [31:0] l);
      return {l[30:0], l[31] ^ l[21] ^ l[1] ^ l[0]};
   endfunction

   function automatic longint interval_of(input longint m, input int n, input logic [31:0] l);
      longint mask = (longint'(1) << n) - 1;
      longint s = m + (longint'(l) & mask);
      return (s == 0) ? 1 : s;
   endfunction

   // Monitor: pop the expected strobe cycle and compare
   always @(negedge clk) begin
      longint e;
      string  r;
      if (rst_n && trig_pulse) begin
         mdl_cnt++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected strobe", cyc, -1);
         end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(cyc == e, r, cyc, e);
         end
         check(trig_count == CW'(mdl_cnt), "R7 strobe count", longint'(trig_count), mdl_cnt);
      end
   end

   // Driver: enable with params (ma,na); switch to (mb,nb) one cycle later
   task automatic run(input longint ma, input int na, input longint mb, input int nb,
                      input int k, input string req);
      longint t;
      @(negedge clk);
      base_period = PW'(ma);
      rand_exp    = EW'(na);
      enable      = 1'b1;
      t = cyc + 1;
      t += interval_of(ma, na, mdl_lfsr);
      mdl_lfsr = lfsr_next(mdl_lfsr);
      exp_q.push_back(t);
      req_q.push_back(req);
      for (int i = 1; i < k; i++) begin
         t += interval_of(mb, nb, mdl_lfsr);
         mdl_lfsr = lfsr_next(mdl_lfsr);
         exp_q.push_back(t);
         req_q.push_back(req);
      end
      mdl_lfsr = lfsr_next(mdl_lfsr);   // draw made at the last strobe
      @(negedge clk);
      base_period = PW'(mb);
      rand_exp    = EW'(nb);
      while (exp_q.size() != 0) begin
         @(negedge clk);
         #1;
      end
      enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      logic [CW-1:0] held;
      repeat (5) @(negedge clk);
      check(trig_pulse == 1'b0, "R1 pulse in reset", longint'(trig_pulse), 0);
      check(trig_count == '0, "R1 count in reset", longint'(trig_count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(trig_pulse == 1'b0, "R1 pulse after reset", longint'(trig_pulse), 0);
      check(trig_count == '0, "R1 count after reset", longint'(trig_count), 0);

      // R6: parameters set but enable low: nothing happens
      base_period = 3;
      rand_exp    = 2;
      repeat (40) @(negedge clk);
      check(trig_count == '0, "R6 idle count", longint'(trig_count), 0);

      run(5, 0, 5, 0, 4, "R2 fixed spacing");
      run(3, 4, 3, 4, 6, "R3 jitter spacing");
      run(7, 2, 7, 2, 5, "R3 jitter spacing");
      run(0, 0, 0, 0, 3, "R4 zero period");
      run(0, 2, 0, 2, 4, "R4 zero period with jitter");
      run(6, 0, 9, 2, 4, "R5 mid-interval change");
      run(12, 3, 4, 0, 3, "R5 mid-interval change");

      // R6: drop enable mid-interval, then restart from a full interval
      @(negedge clk);
      base_period = 20;
      rand_exp    = 3;
      enable      = 1'b1;
      mdl_lfsr    = lfsr_next(mdl_lfsr);
      repeat (8) @(negedge clk);
      #1 enable = 1'b0;
      held = trig_count;
      repeat (40) @(negedge clk);
      check(trig_count == held, "R6 count held while disabled", longint'(trig_count), longint'(held));
      check(trig_pulse == 1'b0, "R6 no strobe while disabled", longint'(trig_pulse), 0);
      run(4, 1, 4, 1, 3, "R6 restart timing");

      run(62500, 0, 62500, 0, 1, "R2 base rate");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vec++;
         bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

endmodule